// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Parity and Channel Test Modes

This block is a two-wire asynchronous serial port. A receiver and a transmitter work independently, but both take their timing from one shared baud generator. Each character travels as a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit, on a line that idles high. Parity can be even, odd, forced to 0 or forced to 1. The receiver flags parity, framing and overrun errors and holds each flag until software clears it.

Software uses the block through a small register bus. One register holds the configuration, one holds the status, and there are separate transmit data, receive data and baud divisor registers. Two request lines let an external transfer engine serve each direction: one says a received character is waiting, the other says the transmit holding register can take a byte. Three channel modes reroute the pins for testing. Echo mode copies the incoming line to the output. Local loopback feeds the transmitter straight into the receiver. Remote loopback ties the pins together and cuts off both engines.

Top module: `serial_xcvr`

## Requirements
- R1: After reset, `tx_o` is 1, `tx_req_o` is 1 and `rx_req_o` is 0. STATUS (address 1) reads 0x0006. The STATUS bits are: bit0 receive data ready, bit1 transmit holding register empty, bit2 transmitter fully idle, bit3 overrun, bit4 framing error, bit5 parity error.
- R2: The DIVISOR register (address 4) sets one bit time to 16 × DIVISOR clock cycles. A divisor of 0 stops the generator: no character starts and `tx_o` stays high.
- R3: A frame is a 0 start bit, then data bits 0..7 in that order, then the parity bit if enabled, then a 1 stop bit. Writing address 2 queues a byte for transmission.
- R4: The parity select field is CTRL (address 0) bits [2:0]. 0 selects even parity (the data bits plus the parity bit hold an even number of ones). 1 selects odd parity, 2 a constant 0 parity bit, and 3 a constant 1 parity bit. Values 4 to 7 send and expect no parity bit.
- R5: When a character arrives, its byte can be read at address 3, and both STATUS bit0 and `rx_req_o` become 1. A read of address 3 clears them.
- R6: If the received parity bit does not match the selected rule, STATUS bit5 is set.
- R7: If the stop bit is sampled low, STATUS bit4 is set.
- R8: If a character completes while the previous one is still unread, STATUS bit3 is set and the new byte replaces the old one.
- R9: Writing CTRL with bit 8 set clears STATUS bits 3, 4 and 5. The error flags stay set until then.
- R10: The channel mode is CTRL bits [5:4]; 0 is normal. Mode 1 (echo) drives `tx_o` from `rx_i`, still delivers incoming characters to the receiver, and drops the transmitter's output.
- R11: Mode 2 (local loopback) feeds the transmitter's output into the receiver and holds `tx_o` at 1.
- R12: Mode 3 (remote loopback) drives `tx_o` from `rx_i`. The receiver sees no characters and the transmitter has no effect on `tx_o`.
- R13: `tx_req_o` (STATUS bit1) is 0 while the transmit holding register holds a byte that the shifter has not yet taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effects only) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| rx_i | input | 1 | Serial input line |
| tx_o | output | 1 | Serial output line |
| rx_req_o | output | 1 | Receive character waiting |
| tx_req_o | output | 1 | Transmit holding register free |

## Verification
The bench keeps the default widths: 8 data bits, 16× oversampling and a 16-bit divisor. It programs a divisor of 4, so one bit lasts 64 clocks. That is long enough for mid-bit sampling and the 8-tick start confirmation to land on distinct ticks, and short enough to send about thirty frames. A divisor of 0 is used to show the generator stalling. Restoring 4 then lets the start bit be measured at exactly 64 cycles. All five parity encodings and all four channel modes are driven at the pins.

// File: rtl/sxc_pkg.sv
package sxc_pkg;
  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_mode_e;

  typedef enum logic [2:0] {
    FS_IDLE, FS_START, FS_DATA, FS_PAR, FS_STOP
  } frame_st_e;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_TXD  = 3'd2;
  localparam logic [2:0] A_RXD  = 3'd3;
  localparam logic [2:0] A_DIV  = 3'd4;

  function automatic logic par_en(input logic [2:0] sel);
    return !sel[2];
  endfunction

  function automatic logic par_calc(input logic [2:0] sel, input logic [7:0] d);
    case (sel)
      3'd0:    par_calc = ^d;
      3'd1:    par_calc = ~^d;
      3'd3:    par_calc = 1'b1;
      default: par_calc = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sxc_baud.sv
module sxc_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (div_i == '0) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q >= div_i - 1'b1) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  assert_tick_needs_div_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(div_i) != '0);
endmodule

// File: rtl/sxc_tx.sv
module sxc_tx
  import sxc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [2:0]        par_sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              thr_empty_o,
  output logic              idle_o,
  output logic              line_o
);
  localparam int OS_W  = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);

  frame_st_e         st_q;
  logic [DATA_W-1:0] thr_q, sh_q;
  logic              thr_full_q, par_q;
  logic [OS_W-1:0]   os_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= FS_IDLE; thr_q <= '0; sh_q <= '0; thr_full_q <= 1'b0;
      par_q <= 1'b0; os_q <= '0; idx_q <= '0; line_o <= 1'b1;
    end else begin
      if (st_q == FS_IDLE) begin
        line_o <= 1'b1;
        if (thr_full_q && tick_i) begin
          sh_q       <= thr_q;
          par_q      <= par_calc(par_sel_i, thr_q);
          thr_full_q <= 1'b0;
          os_q       <= '0;
          line_o     <= 1'b0;
          st_q       <= FS_START;
        end
      end else if (tick_i) begin
        if (os_q != OS_W'(OSR - 1)) begin
          os_q <= os_q + 1'b1;
        end else begin
          os_q <= '0;
          case (st_q)
            FS_START: begin
              line_o <= sh_q[0];
              idx_q  <= '0;
              st_q   <= FS_DATA;
            end
            FS_DATA: begin
              if (idx_q == IDX_W'(DATA_W - 1)) begin
                line_o <= par_en(par_sel_i) ? par_q : 1'b1;
                st_q   <= par_en(par_sel_i) ? FS_PAR : FS_STOP;
              end else begin
                sh_q   <= sh_q >> 1;
                line_o <= sh_q[1];
                idx_q  <= idx_q + 1'b1;
              end
            end
            FS_PAR: begin
              line_o <= 1'b1;
              st_q   <= FS_STOP;
            end
            default: st_q <= FS_IDLE;
          endcase
        end
      end
      if (wr_i) begin
        thr_q      <= wdata_i;
        thr_full_q <= 1'b1;
      end
    end
  end

  assign thr_empty_o = !thr_full_q;
  assign idle_o      = (st_q == FS_IDLE) && !thr_full_q;

  assert_line_high_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == FS_IDLE) |-> line_o);
  assert_thr_taken_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_full_q && st_q == FS_IDLE && tick_i) |=> (st_q == FS_START && !line_o));
endmodule

// File: rtl/sxc_rx.sv
module sxc_rx
  import sxc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic [2:0]        par_sel_i,
  input  logic              rd_clr_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              ovr_o,
  output logic              fe_o,
  output logic              pe_o
);
  localparam int OS_W  = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);

  frame_st_e         st_q;
  logic [DATA_W-1:0] sh_q;
  logic [OS_W-1:0]   os_q;
  logic [IDX_W-1:0]  idx_q;
  logic              par_ok_q;
  logic              fin;

  assign fin = tick_i && (st_q == FS_STOP) && (os_q == OS_W'(OSR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= FS_IDLE; sh_q <= '0; os_q <= '0; idx_q <= '0; par_ok_q <= 1'b1;
      data_o <= '0; ready_o <= 1'b0; ovr_o <= 1'b0; fe_o <= 1'b0; pe_o <= 1'b0;
    end else begin
      if (rd_clr_i) ready_o <= 1'b0;
      if (tick_i) begin
        case (st_q)
          FS_IDLE: if (!line_i) begin
            os_q <= '0;
            st_q <= FS_START;
          end
          FS_START: begin
            if (os_q == OS_W'(OSR / 2 - 1)) begin
              os_q  <= '0;
              idx_q <= '0;
              st_q  <= line_i ? FS_IDLE : FS_DATA;  // reject glitch starts
            end else os_q <= os_q + 1'b1;
          end
          default: begin
            if (os_q != OS_W'(OSR - 1)) begin
              os_q <= os_q + 1'b1;
            end else begin
              os_q <= '0;
              case (st_q)
                FS_DATA: begin
                  sh_q <= {line_i, sh_q[DATA_W-1:1]};
                  if (idx_q == IDX_W'(DATA_W - 1))
                    st_q <= par_en(par_sel_i) ? FS_PAR : FS_STOP;
                  else idx_q <= idx_q + 1'b1;
                end
                FS_PAR: begin
                  par_ok_q <= (line_i == par_calc(par_sel_i, sh_q));
                  st_q     <= FS_STOP;
                end
                default: begin
                  data_o  <= sh_q;
                  ready_o <= 1'b1;
                  if (ready_o && !rd_clr_i) ovr_o <= 1'b1;
                  if (!line_i) fe_o <= 1'b1;
                  if (par_en(par_sel_i) && !par_ok_q) pe_o <= 1'b1;
                  par_ok_q <= 1'b1;
                  st_q     <= FS_IDLE;
                end
              endcase
            end
          end
        endcase
      end
      if (err_clr_i) begin
        ovr_o <= 1'b0; fe_o <= 1'b0; pe_o <= 1'b0;
      end
    end
  end

  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i |=> !(ovr_o || fe_o || pe_o));
  assert_overrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && ready_o && !rd_clr_i && !err_clr_i) |=> ovr_o);
  assert_read_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !fin) |=> !ready_o);
  assert_ready_on_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(st_q) == FS_STOP);
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
  import sxc_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int BUS_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  input  logic             rx_i,
  output logic             tx_o,
  output logic             rx_req_o,
  output logic             tx_req_o
);
  logic [2:0]       par_sel_q;
  chan_mode_e       mode_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       rx_sync_q;
  logic             tick, tx_line, rx_line, thr_empty, tx_idle;
  logic             rx_rdy, ovr, fe, pe, err_clr, rd_clr;
  logic [DATA_W-1:0] rx_data;

  assign err_clr = wr_i && addr_i == A_CTRL && wdata_i[8];
  assign rd_clr  = rd_i && addr_i == A_RXD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_sel_q <= 3'd0;
      mode_q    <= CH_NORMAL;
      div_q     <= '0;
      rx_sync_q <= 2'b11;
    end else begin
      rx_sync_q <= {rx_sync_q[0], rx_i};
      if (wr_i && addr_i == A_CTRL) begin
        par_sel_q <= wdata_i[2:0];
        mode_q    <= chan_mode_e'(wdata_i[5:4]);
      end
      if (wr_i && addr_i == A_DIV) div_q <= wdata_i[DIV_W-1:0];
    end
  end

  always_comb begin
    case (mode_q)
      CH_LOCAL:  begin rx_line = tx_line;      tx_o = 1'b1; end
      CH_REMOTE: begin rx_line = 1'b1;         tx_o = rx_i; end
      CH_ECHO:   begin rx_line = rx_sync_q[1]; tx_o = rx_i; end
      default:   begin rx_line = rx_sync_q[1]; tx_o = tx_line; end
    endcase
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: rdata_o = BUS_W'({mode_q, 1'b0, par_sel_q});
      A_STAT: rdata_o = BUS_W'({pe, fe, ovr, tx_idle, thr_empty, rx_rdy});
      A_RXD:  rdata_o = BUS_W'(rx_data);
      A_DIV:  rdata_o = BUS_W'(div_q);
      default: rdata_o = '0;
    endcase
  end

  assign rx_req_o = rx_rdy;
  assign tx_req_o = thr_empty;

  sxc_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .div_i(div_q), .tick_o(tick)
  );

  sxc_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .par_sel_i(par_sel_q),
    .wr_i(wr_i && addr_i == A_TXD), .wdata_i(wdata_i[DATA_W-1:0]),
    .thr_empty_o(thr_empty), .idle_o(tx_idle), .line_o(tx_line)
  );

  sxc_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .line_i(rx_line), .par_sel_i(par_sel_q),
    .rd_clr_i(rd_clr), .err_clr_i(err_clr), .data_o(rx_data),
    .ready_o(rx_rdy), .ovr_o(ovr), .fe_o(fe), .pe_o(pe)
  );

  assert_tx_hold_empty_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_TXD) |=> !tx_req_o);
endmodule

// File: tb/serial_xcvr_test.sv
module serial_xcvr_test;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;
  localparam int BIT   = 16 * DIV;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        rx = 1'b1, tx, rx_req, tx_req;

  int n_chk = 0, n_fail = 0;
  logic [9:0] exp_q[$];   // {has_par, par, data}
  bit mon_en = 1'b0;
  int echo_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  serial_xcvr uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_i(rx), .tx_o(tx),
    .rx_req_o(rx_req), .tx_req_o(tx_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic epar(input logic [2:0] sel, input logic [7:0] d);
    case (sel)
      3'd0: return ^d;
      3'd1: return ~^d;
      3'd3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic set_ctrl(input logic [1:0] mode, input logic [2:0] par, input bit clr);
    bus_wr(3'd0, 16'((clr ? 16'h100 : 16'h0) | (16'(mode) << 4) | 16'(par)));
  endtask

  task automatic send_tx(input logic [7:0] d, input logic [2:0] sel, input bit expect_out);
    logic [15:0] s;
    do bus_rd(3'd1, s); while (!s[1]);
    if (expect_out) exp_q.push_back({!sel[2], epar(sel, d), d});
    bus_wr(3'd2, {8'h0, d});
  endtask

  task automatic wait_tx_done();
    logic [15:0] s;
    do bus_rd(3'd1, s); while (!s[2] || exp_q.size() != 0);
    repeat (BIT) @(posedge clk);
  endtask

  task automatic drive_rx(input logic [7:0] d, input bit hp, input logic pb,
                          input logic stopb, input bit chk_echo);
    logic [10:0] bits;
    int n;
    bits = hp ? {stopb, pb, d, 1'b0} : {1'b0, stopb, d, 1'b0};
    n = hp ? 11 : 10;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx = bits[i];
      repeat (BIT / 2) @(negedge clk);
      if (chk_echo && tx !== rx) echo_bad++;
      repeat (BIT / 2 - 1) @(negedge clk);
    end
    @(negedge clk); rx = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  // monitor: decode tx_o and compare with scoreboard
  initial begin
    forever begin
      logic [7:0] d;
      logic pb, st, sb;
      logic [9:0] e;
      @(negedge tx);
      if (mon_en) begin
        repeat (BIT / 2) @(posedge clk);
        #1 st = tx;
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(posedge clk);
          #1 d[i] = tx;
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected frame", int'(d), 0);
        end else begin
          e = exp_q.pop_front();
          pb = 1'b0;
          if (e[9]) begin
            repeat (BIT) @(posedge clk);
            #1 pb = tx;
          end
          repeat (BIT) @(posedge clk);
          #1 sb = tx;
          chk(st == 1'b0 && sb == 1'b1, "R3 start/stop", int'({st, sb}), 1);
          chk(d == e[7:0], "R3 data", int'(d), int'(e[7:0]));
          if (e[9]) chk(pb == e[8], "R4 parity bit", int'(pb), int'(e[8]));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] s, v;
    int w;
    bit hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    bus_rd(3'd1, s);
    chk(s == 16'h0006, "R1 status", int'(s), 6);
    chk(tx === 1'b1 && tx_req === 1'b1 && rx_req === 1'b0, "R1 pins",
        int'({tx, tx_req, rx_req}), 6);

    bus_wr(3'd4, DIV);
    mon_en = 1'b1;
    // R3/R4 all parity encodings
    for (int p = 0; p < 5; p++) begin
      set_ctrl(2'd0, 3'(p), 1'b0);
      send_tx(8'hA5, 3'(p), 1'b1);
      send_tx(8'h3C, 3'(p), 1'b1);
      wait_tx_done();
    end
    // R13 holding register full while shifter busy
    set_ctrl(2'd0, 3'd1, 1'b0);
    send_tx(8'h81, 3'd1, 1'b1);
    repeat (2 * DIV + 2) @(negedge clk);
    send_tx(8'h7E, 3'd1, 1'b1);
    #1 chk(tx_req === 1'b0, "R13 tx_req low", int'(tx_req), 0);
    wait_tx_done();

    // R5 receive
    set_ctrl(2'd0, 3'd0, 1'b0);
    drive_rx(8'h5A, 1'b1, epar(3'd0, 8'h5A), 1'b1, 1'b0);
    bus_rd(3'd1, s);
    chk(s[5:0] == 6'b000111 && rx_req === 1'b1, "R5 ready", int'(s), 7);
    bus_rd(3'd3, v);
    chk(v[7:0] == 8'h5A, "R5 data", int'(v), 'h5A);
    bus_rd(3'd1, s);
    chk(s[0] == 1'b0 && rx_req === 1'b0, "R5 read clears", int'(s), 6);

    // R6 parity error
    drive_rx(8'h81, 1'b1, 1'b1, 1'b1, 1'b0);
    bus_rd(3'd1, s);
    chk(s[5] == 1'b1 && s[4:3] == 2'b00, "R6 parity err", int'(s[5:3]), 4);
    bus_rd(3'd3, v);
    // R7 framing error
    drive_rx(8'h0F, 1'b1, epar(3'd0, 8'h0F), 1'b0, 1'b0);
    bus_rd(3'd1, s);
    chk(s[4] == 1'b1 && s[5] == 1'b1, "R7 framing err, R9 sticky", int'(s[5:3]), 6);
    bus_rd(3'd3, v);
    // R9 clear
    set_ctrl(2'd0, 3'd0, 1'b1);
    bus_rd(3'd1, s);
    chk(s[5:3] == 3'b000, "R9 cleared", int'(s[5:3]), 0);

    // R8 overrun, R4 space parity on receive
    set_ctrl(2'd0, 3'd2, 1'b0);
    drive_rx(8'h11, 1'b1, 1'b0, 1'b1, 1'b0);
    drive_rx(8'h22, 1'b1, 1'b0, 1'b1, 1'b0);
    bus_rd(3'd1, s);
    chk(s[3] == 1'b1 && s[5] == 1'b0, "R8 overrun", int'(s[5:3]), 1);
    bus_rd(3'd3, v);
    chk(v[7:0] == 8'h22, "R8 newest kept", int'(v), 'h22);
    set_ctrl(2'd0, 3'd4, 1'b1);
    // R4 no-parity receive
    drive_rx(8'h96, 1'b0, 1'b0, 1'b1, 1'b0);
    bus_rd(3'd1, s);
    bus_rd(3'd3, v);
    chk(s[0] && s[5:3] == 3'b000 && v[7:0] == 8'h96, "R4 no parity rx", int'(v), 'h96);

    // R10 echo
    mon_en = 1'b0;
    set_ctrl(2'd1, 3'd1, 1'b0);
    echo_bad = 0;
    drive_rx(8'hC6, 1'b1, epar(3'd1, 8'hC6), 1'b1, 1'b1);
    chk(echo_bad == 0, "R10 echo follows rx", echo_bad, 0);
    bus_rd(3'd3, v);
    chk(v[7:0] == 8'hC6, "R10 receiver gets data", int'(v), 'hC6);
    send_tx(8'h00, 3'd1, 1'b0);
    hi = 1'b1;
    for (int i = 0; i < 12 * BIT; i++) begin @(negedge clk); if (tx !== 1'b1) hi = 1'b0; end
    chk(hi, "R10 transmitter dropped", int'(hi), 1);

    // R11 local loopback
    set_ctrl(2'd2, 3'd0, 1'b0);
    send_tx(8'hC3, 3'd0, 1'b0);
    hi = 1'b1;
    for (int i = 0; i < 12 * BIT; i++) begin @(negedge clk); if (tx !== 1'b1) hi = 1'b0; end
    chk(hi, "R11 tx pin idle", int'(hi), 1);
    bus_rd(3'd1, s);
    bus_rd(3'd3, v);
    chk(s[0] && v[7:0] == 8'hC3 && s[5:3] == 3'b000, "R11 looped data", int'(v), 'hC3);

    // R12 remote loopback
    set_ctrl(2'd3, 3'd0, 1'b0);
    send_tx(8'h00, 3'd0, 1'b0);
    echo_bad = 0;
    drive_rx(8'h3E, 1'b1, epar(3'd0, 8'h3E), 1'b1, 1'b1);
    repeat (2 * BIT) @(negedge clk);
    chk(echo_bad == 0 && tx === 1'b1, "R12 pin pass-through", echo_bad, 0);
    bus_rd(3'd1, s);
    chk(s[0] == 1'b0 && rx_req === 1'b0, "R12 receiver cut off", int'(s), 6);

    // R2 divisor zero stalls, then exact bit time
    set_ctrl(2'd0, 3'd0, 1'b0);
    bus_wr(3'd4, 16'd0);
    bus_wr(3'd2, 16'h0055);
    hi = 1'b1;
    for (int i = 0; i < 20 * BIT; i++) begin @(negedge clk); if (tx !== 1'b1) hi = 1'b0; end
    chk(hi && tx_req === 1'b0, "R2 div0 stall", int'({hi, tx_req}), 2);
    exp_q.push_back({1'b1, epar(3'd0, 8'h55), 8'h55});
    mon_en = 1'b1;
    bus_wr(3'd4, DIV);
    @(negedge tx);
    w = 0;
    while (tx === 1'b0) begin @(posedge clk); #1 w++; end
    chk(w == BIT, "R2 bit time", w, BIT);
    wait_tx_done();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule